// File: doc/BRIEF.md
# Dual-Channel DAC Register Controller

This block holds the digital register state of a two-channel, 12-bit voltage-output converter. It receives complete 24-bit command frames that a serial front end has already assembled, one frame per cycle with a valid strobe. It applies each frame to a staged register pair per channel. The first stage is a holding register that software writes. The second stage is the active register, which drives the converter code outputs.

A channel's active register is loaded in one of four ways: a frame command, the current level of an active-low load pin, a falling edge on that load pin, or a direct write-and-update command. A mask register can shield a channel from the load pin. A power-down field per channel and an internal-reference enable are reported as status outputs.

Both a synchronous hardware reset and a software-reset command return every register to a common power-on state. In that state the reset-select pin chooses between a zero-scale and a midscale code.

Top module: `dacreg_ctrl`

## Requirements
- R1: A frame carries command in bits [23:20], channel-select in bits [19:16] and data in [15:0]. The 12-bit code is data[15:4]. Select bit 16 addresses channel A and bit 19 addresses channel B, and both may be set together. All effects of a frame are visible on the outputs after the clock edge that samples it.
- R2: Command 0001 writes the code into the holding register of each selected channel. While the load pin is high, the active register is left unchanged.
- R3: Command 0001 also loads the active register in the same cycle when the load pin is low and that channel's mask bit is 0. A masked channel is not loaded.
- R4: Command 0010 copies the holding register of each selected channel into its active register.
- R5: Command 0011 writes the code into both the holding and the active register of each selected channel.
- R6: The load pin is registered once. A cycle in which it is sampled low after being high copies holding to active for every channel whose mask bit is 0. Command 0101 sets the mask from data bit 0 (channel A) and data bit 3 (channel B). A frame that loads a channel's active register takes precedence over the pin.
- R7: Command 0100 sets channel A powered-down when data[1:0] is nonzero and channel B powered-down when data[7:6] is nonzero. A zero field restores normal operation. pwr_dn bit 0 reports A and bit 1 reports B.
- R8: Command 0111 sets ref_on to the inverse of data bit 0.
- R9: Command 0110 restores the power-on state: both codes at the reset value, mask cleared, both channels powered up, ref_on high.
- R10: rst_n low at a clock edge restores the same power-on state. The reset value is 0x000 when rst_sel is low and 0x800 when it is high.
- R11: Command 0000, commands 1000 to 1111, and any frame with frm_vld low change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous hardware reset, active low |
| rst_sel | input | 1 | Reset code select: 0 zero scale, 1 midscale |
| ld_n | input | 1 | Active-low load pin |
| frm_vld | input | 1 | Frame valid strobe |
| frm_data | input | 24 | Command frame |
| dac_code_a | output | 12 | Active code of channel A |
| dac_code_b | output | 12 | Active code of channel B |
| pwr_dn | output | 2 | Powered-down status, bit 0 channel A |
| ref_on | output | 1 | Internal reference enabled |

## Verification
Several properties are checked on every cycle:
- leaving reset shows the selected reset code;
- reserved and no-op frames leave all state untouched;
- a masked channel with no frame holds its code;
- write-and-update, copy, power-down and reference frames give their results one cycle later.

Only the bench scenarios show the interplay between the load pin's level and its edge, the mask taking effect one frame late, and the precedence of frames over a simultaneous pin edge. The bench checks these against a behavioural model on every clock.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;
  localparam int CODE_W = 12;
  localparam int DATA_W = 16;
  localparam int CMD_W  = 4;
  localparam int SEL_W  = 4;
  localparam int FRM_W  = CMD_W + SEL_W + DATA_W;
  localparam int NCH    = 2;

  localparam logic [CMD_W-1:0] OP_NOP    = 4'b0000;
  localparam logic [CMD_W-1:0] OP_WR_IN  = 4'b0001;
  localparam logic [CMD_W-1:0] OP_UPD    = 4'b0010;
  localparam logic [CMD_W-1:0] OP_WR_UPD = 4'b0011;
  localparam logic [CMD_W-1:0] OP_PWR    = 4'b0100;
  localparam logic [CMD_W-1:0] OP_MASK   = 4'b0101;
  localparam logic [CMD_W-1:0] OP_SRST   = 4'b0110;
  localparam logic [CMD_W-1:0] OP_REF    = 4'b0111;

  typedef struct packed {
    logic wr_in;
    logic upd;
    logic wr_upd;
    logic pwr;
    logic mask;
    logic srst;
    logic refc;
  } op_dec_t;

  // channel-select / mask bit position for a channel
  function automatic int sel_pos(input int ch);
    return (ch == 0) ? 0 : 3;
  endfunction

  // low bit of the 2-bit power-down field for a channel
  function automatic int pd_lsb(input int ch);
    return (ch == 0) ? 0 : 6;
  endfunction

  function automatic logic [CODE_W-1:0] code_of(input logic [DATA_W-1:0] d);
    return d[DATA_W-1 -: CODE_W];
  endfunction

  function automatic logic [CODE_W-1:0] reset_code(input logic mid);
    return mid ? {1'b1, {(CODE_W-1){1'b0}}} : '0;
  endfunction
endpackage

// File: rtl/dacreg_decode.sv
module dacreg_decode
  import dacreg_pkg::*;
#(
  parameter int N_CH = NCH
) (
  input  logic              vld,
  input  logic [FRM_W-1:0]  frame,
  output op_dec_t           dec,
  output logic [N_CH-1:0]   sel,
  output logic [DATA_W-1:0] data
);
  localparam int OP_LSB  = DATA_W + SEL_W;
  localparam int SEL_LSB = DATA_W;

  logic [CMD_W-1:0] op;
  logic [SEL_W-1:0] addr;

  assign op   = frame[OP_LSB +: CMD_W];
  assign addr = frame[SEL_LSB +: SEL_W];
  assign data = frame[DATA_W-1:0];

  always_comb begin
    dec = '0;
    if (vld) begin
      case (op)
        OP_WR_IN:  dec.wr_in  = 1'b1;
        OP_UPD:    dec.upd    = 1'b1;
        OP_WR_UPD: dec.wr_upd = 1'b1;
        OP_PWR:    dec.pwr    = 1'b1;
        OP_MASK:   dec.mask   = 1'b1;
        OP_SRST:   dec.srst   = 1'b1;
        OP_REF:    dec.refc   = 1'b1;
        default:   dec        = '0;
      endcase
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_sel
    assign sel[c] = addr[sel_pos(c)];
  end
endmodule

// File: rtl/dacreg_chan.sv
module dacreg_chan #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rst_val,
  input  logic         srst,
  input  logic         wr_hold,
  input  logic         load_new,
  input  logic         load_copy,
  input  logic [W-1:0] new_code,
  output logic [W-1:0] hold_q,
  output logic [W-1:0] act_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      hold_q <= rst_val;
      act_q  <= rst_val;
    end else begin
      if (wr_hold) hold_q <= new_code;
      if (load_new)       act_q <= new_code;
      else if (load_copy) act_q <= hold_q;
    end
  end
endmodule

// File: rtl/dacreg_cfg.sv
module dacreg_cfg
  import dacreg_pkg::*;
#(
  parameter int N_CH = NCH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_dec_t           dec,
  input  logic [DATA_W-1:0] data,
  input  logic              ld_n,
  output logic [N_CH-1:0]   mask_q,
  output logic [N_CH-1:0]   pd_q,
  output logic              ref_q,
  output logic              ld_fall
);
  logic ld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ld_q <= 1'b1;
    else        ld_q <= ld_n;
  end
  assign ld_fall = ld_q & ~ld_n;

  always_ff @(posedge clk) begin
    if (!rst_n || dec.srst)  ref_q <= 1'b1;
    else if (dec.refc)       ref_q <= ~data[0];
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n || dec.srst) begin
        mask_q[c] <= 1'b0;
        pd_q[c]   <= 1'b0;
      end else begin
        if (dec.mask) mask_q[c] <= data[sel_pos(c)];
        if (dec.pwr)  pd_q[c]   <= |data[pd_lsb(c) +: 2];
      end
    end
  end
endmodule

// File: rtl/dacreg_ctrl.sv
module dacreg_ctrl
  import dacreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_sel,
  input  logic              ld_n,
  input  logic              frm_vld,
  input  logic [FRM_W-1:0]  frm_data,
  output logic [CODE_W-1:0] dac_code_a,
  output logic [CODE_W-1:0] dac_code_b,
  output logic [NCH-1:0]    pwr_dn,
  output logic              ref_on
);
  op_dec_t           dec;
  logic [NCH-1:0]    sel;
  logic [DATA_W-1:0] data;
  logic [NCH-1:0]    ld_mask;
  logic              ld_fall;
  logic [CODE_W-1:0] new_code;
  logic [CODE_W-1:0] rst_val;
  logic [CODE_W-1:0] in_code [NCH];
  logic [CODE_W-1:0] act_code [NCH];
  logic [NCH-1:0]    wr_hold;
  logic [NCH-1:0]    load_new;
  logic [NCH-1:0]    load_copy;

  dacreg_decode #(.N_CH(NCH)) u_dec (
    .vld   (frm_vld),
    .frame (frm_data),
    .dec   (dec),
    .sel   (sel),
    .data  (data)
  );

  dacreg_cfg #(.N_CH(NCH)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .dec     (dec),
    .data    (data),
    .ld_n    (ld_n),
    .mask_q  (ld_mask),
    .pd_q    (pwr_dn),
    .ref_q   (ref_on),
    .ld_fall (ld_fall)
  );

  assign new_code = code_of(data);
  assign rst_val  = reset_code(rst_sel);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign wr_hold[c]   = sel[c] & (dec.wr_in | dec.wr_upd);
    assign load_new[c]  = sel[c] & (dec.wr_upd | (dec.wr_in & ~ld_n & ~ld_mask[c]));
    assign load_copy[c] = (sel[c] & dec.upd) | (ld_fall & ~ld_mask[c]);

    dacreg_chan #(.W(CODE_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .rst_val   (rst_val),
      .srst      (dec.srst),
      .wr_hold   (wr_hold[c]),
      .load_new  (load_new[c]),
      .load_copy (load_copy[c]),
      .new_code  (new_code),
      .hold_q    (in_code[c]),
      .act_q     (act_code[c])
    );
  end

  assign dac_code_a = act_code[0];
  assign dac_code_b = act_code[1];
endmodule

// File: rtl/dacreg_ctrl_chk.sv
module dacreg_ctrl_chk
  import dacreg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rst_sel,
  input logic              ld_n,
  input logic              frm_vld,
  input logic [FRM_W-1:0]  frm,
  input logic              ld_fall,
  input logic [NCH-1:0]    mask,
  input logic [CODE_W-1:0] in_a,
  input logic [CODE_W-1:0] dac_a,
  input logic [CODE_W-1:0] dac_b,
  input logic [NCH-1:0]    pwr_dn,
  input logic              ref_on
);
  logic [CODE_W-1:0] exp_rst;
  assign exp_rst = rst_sel ? 12'h800 : 12'h000;

  AST_RST_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dac_a == exp_rst && dac_b == exp_rst && pwr_dn == 2'b00 && ref_on)); // R10

  AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && frm[23] && !ld_fall) |=>
      ($stable(dac_a) && $stable(dac_b) && $stable(pwr_dn) && $stable(ref_on) && $stable(in_a))); // R11

  AST_HOLD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && frm[23:20] == 4'b0001 && ld_n) |=> $stable(dac_a)); // R2

  AST_COPY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && frm[23:20] == 4'b0010 && frm[16]) |=> (dac_a == $past(in_a))); // R4

  AST_WR_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && frm[23:20] == 4'b0011 && frm[19]) |=> (dac_b == $past(frm[15:4]))); // R5

  AST_MASK_SHIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mask[0] && !frm_vld) |=> $stable(dac_a)); // R6

  AST_PWR_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && frm[23:20] == 4'b0100) |=>
      (pwr_dn[0] == |$past(frm[1:0]) && pwr_dn[1] == |$past(frm[7:6]))); // R7

  AST_REF_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && frm[23:20] == 4'b0111) |=> (ref_on == !$past(frm[0]))); // R8

  AST_SOFT_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && frm[23:20] == 4'b0110) |=>
      (dac_a == $past(exp_rst) && dac_b == $past(exp_rst) && pwr_dn == 2'b00 && ref_on)); // R9
endmodule

bind dacreg_ctrl dacreg_ctrl_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .rst_sel (rst_sel),
  .ld_n    (ld_n),
  .frm_vld (frm_vld),
  .frm     (frm_data),
  .ld_fall (ld_fall),
  .mask    (ld_mask),
  .in_a    (in_code[0]),
  .dac_a   (dac_code_a),
  .dac_b   (dac_code_b),
  .pwr_dn  (pwr_dn),
  .ref_on  (ref_on)
);

// File: tb/dacreg_ctrl_tb_top.sv
`timescale 1ns/1ps
module dacreg_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rst_sel = 1'b1;
  logic        ld_n = 1'b1;
  logic        frm_vld = 1'b0;
  logic [23:0] frm_data = '0;
  logic [11:0] dac_code_a, dac_code_b;
  logic [1:0]  pwr_dn;
  logic        ref_on;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int m_in [2];
  int m_dac [2];
  bit m_mask [2];
  bit m_pd [2];
  bit m_ref;
  bit m_prev;

  always #4 clk = ~clk;

  dacreg_ctrl dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sel    (rst_sel),
    .ld_n       (ld_n),
    .frm_vld    (frm_vld),
    .frm_data   (frm_data),
    .dac_code_a (dac_code_a),
    .dac_code_b (dac_code_b),
    .pwr_dn     (pwr_dn),
    .ref_on     (ref_on)
  );

  function automatic logic [23:0] fr(input int c, input int a, input int d);
    return {c[3:0], a[3:0], d[15:0]};
  endfunction

  task automatic model_reset(input bit rn, input bit ldn);
    int rv = rst_sel ? 'h800 : 0;
    foreach (m_in[k]) begin
      m_in[k] = rv; m_dac[k] = rv; m_mask[k] = 0; m_pd[k] = 0;
    end
    m_ref = 1;
    m_prev = rn ? ldn : 1'b1;
  endtask

  task automatic model(input bit v, input logic [23:0] f, input bit ldn, input bit rn);
    int c = int'(f[23:20]);
    int d = int'(f[15:0]);
    int val = d >> 4;
    bit fall;
    int nin [2];
    int ndac [2];
    if (!rn || (v && c == 6)) begin
      model_reset(rn, ldn);
      return;
    end
    fall = m_prev && !ldn;
    for (int k = 0; k < 2; k++) begin
      bit s = v && f[16 + (k == 0 ? 0 : 3)];
      bit set = 0;
      nin[k] = m_in[k];
      ndac[k] = m_dac[k];
      if (s && (c == 1 || c == 3)) nin[k] = val;
      if (s && c == 3) begin ndac[k] = val; set = 1; end
      if (s && c == 1 && !ldn && !m_mask[k]) begin ndac[k] = val; set = 1; end
      if (!set && s && c == 2) begin ndac[k] = m_in[k]; set = 1; end
      if (!set && fall && !m_mask[k]) ndac[k] = m_in[k];
    end
    for (int k = 0; k < 2; k++) begin
      m_in[k] = nin[k];
      m_dac[k] = ndac[k];
    end
    if (v && c == 4) begin
      m_pd[0] = (d & 3) != 0;
      m_pd[1] = ((d >> 6) & 3) != 0;
    end
    if (v && c == 5) begin
      m_mask[0] = d[0];
      m_mask[1] = d[3];
    end
    if (v && c == 7) m_ref = !d[0];
    m_prev = ldn;
  endtask

  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "dac_code_a", int'(dac_code_a), m_dac[0]);
    chk(tag, "dac_code_b", int'(dac_code_b), m_dac[1]);
    chk(tag, "pwr_dn", int'(pwr_dn), int'({m_pd[1], m_pd[0]}));
    chk(tag, "ref_on", int'(ref_on), int'(m_ref));
  endtask

  task automatic tick(input bit v, input logic [23:0] f, input bit ldn, input bit rn, input string tag);
    frm_vld = v; frm_data = f; ld_n = ldn; rst_n = rn;
    @(posedge clk);
    model(v, f, ldn, rn);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    @(negedge clk);
    // R10 midscale reset
    tick(0, '0, 1, 0, "R10 reset mid");
    tick(0, '0, 1, 0, "R10 reset mid");
    tick(0, '0, 1, 1, "R10 after reset");
    // R2 hold write with load pin high, then R4 copy
    tick(1, fr(1, 1, 'hABC0), 1, 1, "R2 hold write");
    tick(0, '0, 1, 1, "R2 idle");
    tick(1, fr(2, 1, 0), 1, 1, "R4 copy A");
    // R5 and R1 both channels
    tick(1, fr(3, 9, 'h1230), 1, 1, "R5 R1 write-update both");
    tick(1, fr(3, 8, 'hFFF0), 1, 1, "R5 R1 B only");
    // R3 passthrough with load low
    tick(1, fr(1, 8, 'h4560), 0, 1, "R3 passthrough B");
    tick(0, '0, 0, 1, "R3 low hold");
    // R6 falling edge
    tick(0, '0, 1, 1, "R6 raise");
    tick(1, fr(1, 1, 'h7770), 1, 1, "R6 stage A");
    tick(0, '0, 0, 1, "R6 edge loads A");
    tick(0, '0, 1, 1, "R6 raise");
    // R6 mask channel A
    tick(1, fr(5, 0, 'h0001), 1, 1, "R6 mask A");
    tick(1, fr(1, 1, 'h1110), 1, 1, "R6 stage A");
    tick(1, fr(1, 8, 'h2220), 1, 1, "R6 stage B");
    tick(0, '0, 0, 1, "R6 edge masked A");
    tick(1, fr(1, 1, 'h3330), 0, 1, "R3 masked no passthrough");
    tick(1, fr(2, 1, 0), 0, 1, "R4 copy while masked");
    tick(1, fr(5, 0, 'h0008), 1, 1, "R6 mask B");
    tick(1, fr(1, 9, 'h5550), 1, 1, "R6 stage both");
    tick(1, fr(3, 1, 'h6660), 0, 1, "R6 frame beats edge");
    tick(1, fr(5, 0, 0), 1, 1, "R6 unmask");
    // R7 power-down
    tick(1, fr(4, 0, 'h0042), 1, 1, "R7 pd both");
    tick(1, fr(4, 9, 'h0000), 1, 1, "R7 pd clear");
    tick(1, fr(4, 0, 'h0080), 1, 1, "R7 pd B");
    tick(1, fr(4, 0, 'h003C), 1, 1, "R7 middle bits ignored");
    // R8 reference
    tick(1, fr(7, 0, 1), 1, 1, "R8 ref off");
    tick(1, fr(7, 0, 0), 1, 1, "R8 ref on");
    tick(1, fr(7, 0, 1), 1, 1, "R8 ref off");
    // R11 reserved and no-op
    for (int c = 8; c < 16; c++) tick(1, fr(c, 9, 'hFFFF), 1, 1, "R11 reserved");
    tick(1, fr(0, 9, 'hFFFF), 1, 1, "R11 nop");
    tick(0, fr(3, 9, 'h9990), 1, 1, "R11 no valid");
    tick(1, fr(2, 9, 0), 1, 1, "R11 hold unchanged");
    // R9 software reset
    tick(1, fr(6, 0, 0), 1, 1, "R9 soft reset mid");
    rst_sel = 1'b0;
    tick(1, fr(3, 9, 'hABCD), 1, 1, "R5 before reset");
    tick(0, '0, 1, 0, "R10 reset zero");
    tick(0, '0, 1, 1, "R10 after zero reset");
    tick(1, fr(3, 9, 'h8880), 1, 1, "R5 before soft");
    tick(1, fr(7, 0, 1), 1, 1, "R8 before soft");
    tick(1, fr(6, 0, 0), 1, 1, "R9 soft reset zero");
    // random mix of everything
    for (int i = 0; i < 400; i++) begin
      int c = $urandom_range(0, 15);
      if (c == 6 && $urandom_range(0, 3) != 0) c = 3;
      tick($urandom_range(0, 3) != 0, fr(c, $urandom_range(0, 15), $urandom_range(0, 65535)),
           $urandom_range(0, 2) != 0, 1, "R11 random mix");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule